// File: doc/BRIEF.md
# Dual-Core Powerdown and Clock Controller

This block sequences the power state of two processor cores that run from one shared clock generator. Software drives each core through a small control/status register on a simple write/read bus. The register carries a power-down request bit and a power-up request bit. The same two bits, when read, report where that core currently sits in its power sequence.

A power-down request sends the core into its powerdown interrupt handler. When the core then executes its idle instruction, its clock is gated off. A power-up request releases it again. A request written at the wrong moment aborts the transition in progress. A power-up written before the idle lets execution run straight through the idle. A power-down written after wake-up makes the core re-enter the handler once it returns from the interrupt.

When both cores are stopped, the shared clock generator is switched off. It restarts by itself when either core is woken, and it has to wait out a lock period before any core clock is released. Host memory access to the cores is refused while the generator is not stable and while any core is waking.

Top module: `pwr_ctl`

## Requirements
- R1: After reset both cores run, both core clock enables are high, the clock generator runs and is stable, both status registers read 0 and memory access is not blocked.
- R2: Writing 1 to bit 0 (power-down) of a running core's register raises that core's handler request for exactly one cycle, and the core's bit 1 (power-up status) then reads 1.
- R3: An idle strobe from a core that is in the handler, with no power-up pending, drops that core's clock enable in the next cycle, and its bit 0 then reads 1.
- R4: Writing 1 to bit 1 of a stopped core's register wakes it. Once the generator is stable, its clock enable rises and bit 0 clears while bit 1 stays 1 until the core's return-from-interrupt strobe, which returns both bits to 0.
- R5: A power-up write made while a core is in the handler before its idle makes the following idle strobe leave the clock running. The following return strobe returns the core to run.
- R6: A power-down write made after a core has woken and before its return strobe makes the return strobe re-enter the handler, with a new one-cycle handler request. The core keeps its clock throughout.
- R7: When both cores are stopped, the clock generator enable output falls in the next cycle. Both core clock enables stay low and both bit-0 status values read 1.
- R8: After a wake write with the generator off, the generator enable rises one cycle later. The woken core's clock enable rises on the (LOCK_CYCLES+2)th clock edge after the edge that samples the write, and no earlier.
- R9: The memory-block output is high whenever the clock generator is not stable or any core is waking.
- R10: Core 1's register sits at page 0, address 0x08, and core 2's register at page 0, address 0x0A. Bit 0 holds power-down and bit 1 holds power-up. A write to any other page or address changes no state, and reads elsewhere return 0.
- R11: A written 0 in either bit has no effect. A write with both bits set acts as a power-up request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_page | input | 8 | Register page |
| bus_addr | input | 8 | Register address within page |
| bus_wdata | input | 2 | Write data: bit 1 power-up, bit 0 power-down |
| bus_rdata | output | 2 | Read status of the addressed core, 0 if unmapped |
| idle_stb | input | 2 | Per-core strobe: idle instruction executed |
| rti_stb | input | 2 | Per-core strobe: return from interrupt executed |
| handler_req | output | 2 | Per-core one-cycle request to enter the powerdown handler |
| core_clk_en | output | 2 | Per-core clock enable |
| gen_run | output | 1 | Enable for the shared clock generator |
| mem_block | output | 1 | Refuse host memory access to the cores |

## Verification
The assertions check on every cycle that the handler request is a single-cycle pulse, and that no core clock is enabled and memory stays blocked while the generator is unstable. They also check that the generator never jumps from off to stable, and that a core clock falls with the generator stable only after an idle strobe. The bench's scenarios are the only place where ordering effects can be shown. These are the two abort paths, the exact lock latency from a wake write to the clock enable, the dual-bit write rule and ignored writes to unmapped addresses, all of which are observed through the status reads and the output pins.

// File: rtl/pwr_ctl_pkg.sv
// Shared types for the dual-core powerdown controller.
// Assumes a 2-bit per-core status/command word.
package pwr_ctl_pkg;

    // Per-core power sequence position
    typedef enum logic [2:0] {
        CS_RUN,
        CS_HANDLER,
        CS_IDLE_STOPPED,
        CS_WAKING,
        CS_REENTER
    } core_st_e;

    // Shared clock generator condition
    typedef enum logic [1:0] {
        GEN_OFF,
        GEN_LOCKING,
        GEN_STABLE
    } gen_st_e;

    localparam int PD_BIT = 0;
    localparam int PU_BIT = 1;

endpackage

// File: rtl/pwr_ctl_regif.sv
// Register decode for the per-core control/status words.
// Produces one-cycle command pulses from bus writes and muxes status on reads.
// Assumes registers are spaced ADDR_STRIDE apart starting at BASE_ADDR on one page.
module pwr_ctl_regif
    import pwr_ctl_pkg::*;
#(
    parameter int NUM_CORES   = 2,
    parameter int PAGE_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int REG_PAGE    = 0,
    parameter int BASE_ADDR   = 8,
    parameter int ADDR_STRIDE = 2
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [PAGE_W-1:0]    bus_page,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_wdata,
    output logic [1:0]           bus_rdata,
    input  logic [NUM_CORES-1:0] pd_stat,
    input  logic [NUM_CORES-1:0] pu_stat,
    output logic [NUM_CORES-1:0] pd_wr,
    output logic [NUM_CORES-1:0] pu_wr
);

    logic [NUM_CORES-1:0] hit;

    // Address match per core register, command pulses and read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            hit[i]   = bus_sel && (bus_page == PAGE_W'(REG_PAGE)) &&
                       (bus_addr == ADDR_W'(BASE_ADDR + i * ADDR_STRIDE));
            pu_wr[i] = hit[i] && bus_we && bus_wdata[PU_BIT];
            pd_wr[i] = hit[i] && bus_we && bus_wdata[PD_BIT] && !bus_wdata[PU_BIT];
            if (hit[i] && !bus_we) begin
                bus_rdata[PD_BIT] = pd_stat[i];
                bus_rdata[PU_BIT] = pu_stat[i];
            end
        end
    end

endmodule

// File: rtl/pwr_ctl_core.sv
// Per-core power sequencer.
// Tracks handler entry, idle, wake and the two abort paths for one core.
// Assumes idle_stb and rti_stb are single-cycle strobes from the core.
module pwr_ctl_core
    import pwr_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_wr,
    input  logic pu_wr,
    input  logic idle_stb,
    input  logic rti_stb,
    input  logic gen_stable,
    output logic handler_req,
    output logic clk_en,
    output logic pd_stat,
    output logic pu_stat,
    output logic stopped,
    output logic waking
);

    core_st_e st;
    logic     skip_idle;   // power-up arrived before the idle
    logic     past_idle;   // core has woken out of its idle
    logic     redo;        // power-down arrived while waking

    // Sequence state and abort flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= CS_RUN;
            skip_idle   <= 1'b0;
            past_idle   <= 1'b0;
            redo        <= 1'b0;
            handler_req <= 1'b0;
        end else begin
            handler_req <= 1'b0;
            case (st)
                CS_RUN: begin
                    if (pd_wr) begin
                        st          <= CS_HANDLER;
                        handler_req <= 1'b1;
                        skip_idle   <= 1'b0;
                        past_idle   <= 1'b0;
                    end
                end
                CS_HANDLER: begin
                    if (rti_stb) begin
                        st        <= CS_RUN;
                        skip_idle <= 1'b0;
                        past_idle <= 1'b0;
                    end else if (pd_wr && past_idle) begin
                        st <= CS_REENTER;
                    end else if (pu_wr && !past_idle) begin
                        skip_idle <= 1'b1;
                    end else if (idle_stb && !past_idle && !skip_idle) begin
                        st <= CS_IDLE_STOPPED;
                    end
                end
                CS_IDLE_STOPPED: begin
                    if (pu_wr) begin
                        st   <= CS_WAKING;
                        redo <= 1'b0;
                    end
                end
                CS_WAKING: begin
                    if (gen_stable) begin
                        st        <= (redo || pd_wr) ? CS_REENTER : CS_HANDLER;
                        past_idle <= 1'b1;
                        redo      <= 1'b0;
                    end else if (pd_wr) begin
                        redo <= 1'b1;
                    end
                end
                CS_REENTER: begin
                    if (rti_stb) begin
                        st          <= CS_HANDLER;
                        handler_req <= 1'b1;
                        skip_idle   <= 1'b0;
                        past_idle   <= 1'b0;
                    end
                end
                default: st <= CS_RUN;
            endcase
        end
    end

    // Status bits and clock enable from sequence position
    always_comb begin
        stopped = (st == CS_IDLE_STOPPED);
        waking  = (st == CS_WAKING);
        clk_en  = gen_stable && !stopped && !waking;
        pd_stat = !gen_stable || stopped || waking;
        pu_stat = (st != CS_RUN);
    end

endmodule

// File: rtl/pwr_ctl_clkgen.sv
// Shared clock generator sequencer.
// Turns the generator off when every core is stopped, restarts it otherwise
// and holds stable low for LOCK_CYCLES reference cycles while it locks.
module pwr_ctl_clkgen
    import pwr_ctl_pkg::*;
#(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_stopped,
    output logic gen_run,
    output logic gen_stable
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    gen_st_e          st;
    logic [CNT_W-1:0] cnt;

    // Generator on/off and lock counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= GEN_STABLE;
            cnt <= '0;
        end else begin
            case (st)
                GEN_OFF: begin
                    if (!all_stopped) begin
                        st  <= GEN_LOCKING;
                        cnt <= '0;
                    end
                end
                GEN_LOCKING: begin
                    if (all_stopped)                          st  <= GEN_OFF;
                    else if (cnt == CNT_W'(LOCK_CYCLES - 1)) st  <= GEN_STABLE;
                    else                                      cnt <= cnt + 1'b1;
                end
                GEN_STABLE: begin
                    if (all_stopped) st <= GEN_OFF;
                end
                default: st <= GEN_OFF;
            endcase
        end
    end

    // Generator control and ready indication
    always_comb begin
        gen_run    = (st != GEN_OFF);
        gen_stable = (st == GEN_STABLE);
    end

endmodule

// File: rtl/pwr_ctl.sv
// Dual-core powerdown and clock controller, top level.
// Connects register decode, one sequencer per core and the shared generator.
// Assumes the reference clock runs whenever the generator is off.
module pwr_ctl
    import pwr_ctl_pkg::*;
#(
    parameter int NUM_CORES   = 2,
    parameter int LOCK_CYCLES = 64,
    parameter int PAGE_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int REG_PAGE    = 0,
    parameter int BASE_ADDR   = 8,
    parameter int ADDR_STRIDE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [PAGE_W-1:0]    bus_page,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_wdata,
    output logic [1:0]           bus_rdata,
    input  logic [NUM_CORES-1:0] idle_stb,
    input  logic [NUM_CORES-1:0] rti_stb,
    output logic [NUM_CORES-1:0] handler_req,
    output logic [NUM_CORES-1:0] core_clk_en,
    output logic                 gen_run,
    output logic                 mem_block
);

    logic [NUM_CORES-1:0] pd_wr, pu_wr, pd_stat, pu_stat, stopped, waking;
    logic                 gen_stable;

    pwr_ctl_regif #(
        .NUM_CORES(NUM_CORES), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W),
        .REG_PAGE(REG_PAGE), .BASE_ADDR(BASE_ADDR), .ADDR_STRIDE(ADDR_STRIDE)
    ) u_regif (
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_page(bus_page),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pd_stat(pd_stat), .pu_stat(pu_stat), .pd_wr(pd_wr), .pu_wr(pu_wr)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        pwr_ctl_core u_core (
            .clk(clk), .rst_n(rst_n),
            .pd_wr(pd_wr[g]), .pu_wr(pu_wr[g]),
            .idle_stb(idle_stb[g]), .rti_stb(rti_stb[g]),
            .gen_stable(gen_stable),
            .handler_req(handler_req[g]), .clk_en(core_clk_en[g]),
            .pd_stat(pd_stat[g]), .pu_stat(pu_stat[g]),
            .stopped(stopped[g]), .waking(waking[g])
        );
    end

    pwr_ctl_clkgen #(.LOCK_CYCLES(LOCK_CYCLES)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .all_stopped(&stopped),
        .gen_run(gen_run), .gen_stable(gen_stable)
    );

    // Refuse host memory access while clocks are unavailable
    always_comb mem_block = !gen_stable || (|waking);

endmodule

// File: rtl/pwr_ctl_chk.sv
// Property checker for pwr_ctl, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module pwr_ctl_chk #(
    parameter int NUM_CORES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] idle_stb,
    input logic [NUM_CORES-1:0] handler_req,
    input logic [NUM_CORES-1:0] core_clk_en,
    input logic                 gen_run,
    input logic                 gen_stable,
    input logic                 mem_block
);

    // R7
    clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_stable |-> (core_clk_en == '0));

    // R9
    mem_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_stable |-> mem_block);

    // R8
    lock_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_stable) |-> $past(gen_run));

    // R7
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gen_run) |-> (core_clk_en == '0));

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
        // R2
        req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            handler_req[i] |=> !handler_req[i]);

        // R3
        idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(core_clk_en[i]) && gen_stable) |-> $past(idle_stb[i]));
    end

endmodule

bind pwr_ctl pwr_ctl_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk(clk), .rst_n(rst_n), .idle_stb(idle_stb),
    .handler_req(handler_req), .core_clk_en(core_clk_en),
    .gen_run(gen_run), .gen_stable(gen_stable), .mem_block(mem_block)
);

// File: tb/pwr_ctl_test.sv
// Self-checking bench for pwr_ctl: a vector table walked by one loop,
// then directed tests for reset, pulses, decode and generator restart.
module pwr_ctl_test;

    localparam int CLK_NS = 20;
    localparam int LK     = 8;
    localparam int NV     = 23;

    localparam logic [1:0] OP_WR = 2'd0, OP_IDLE = 2'd1, OP_RTI = 2'd2, OP_WAIT = 2'd3;

    // {op, core, data, wait, exp_clk_en, exp_block, exp_st0, exp_st1, req}
    localparam logic [19:0] VEC [NV] = '{
        {OP_WR,   1'b0, 2'b01, 4'd0, 2'b11, 1'b0, 2'b10, 2'b00, 4'd2},  // R2
        {OP_IDLE, 1'b0, 2'b00, 4'd0, 2'b10, 1'b0, 2'b11, 2'b00, 4'd3},  // R3
        {OP_WR,   1'b0, 2'b10, 4'd0, 2'b10, 1'b1, 2'b11, 2'b00, 4'd4},  // R4 waking
        {OP_WAIT, 1'b0, 2'b00, 4'd1, 2'b11, 1'b0, 2'b10, 2'b00, 4'd4},
        {OP_RTI,  1'b0, 2'b00, 4'd0, 2'b11, 1'b0, 2'b00, 2'b00, 4'd4},
        {OP_WR,   1'b0, 2'b01, 4'd0, 2'b11, 1'b0, 2'b10, 2'b00, 4'd2},
        {OP_WR,   1'b1, 2'b01, 4'd0, 2'b11, 1'b0, 2'b10, 2'b10, 4'd2},
        {OP_IDLE, 1'b0, 2'b00, 4'd0, 2'b10, 1'b0, 2'b11, 2'b10, 4'd3},
        {OP_IDLE, 1'b1, 2'b00, 4'd0, 2'b00, 1'b0, 2'b11, 2'b11, 4'd7},  // R7
        {OP_WAIT, 1'b0, 2'b00, 4'd1, 2'b00, 1'b1, 2'b11, 2'b11, 4'd7},
        {OP_WR,   1'b1, 2'b10, 4'd0, 2'b00, 1'b1, 2'b11, 2'b11, 4'd8},  // R8
        {OP_WAIT, 1'b0, 2'b00, 4'd8, 2'b00, 1'b1, 2'b11, 2'b11, 4'd8},
        {OP_WAIT, 1'b0, 2'b00, 4'd1, 2'b00, 1'b1, 2'b11, 2'b11, 4'd8},
        {OP_WAIT, 1'b0, 2'b00, 4'd1, 2'b10, 1'b0, 2'b11, 2'b10, 4'd8},
        {OP_WR,   1'b1, 2'b01, 4'd0, 2'b10, 1'b0, 2'b11, 2'b10, 4'd6},  // R6
        {OP_RTI,  1'b1, 2'b00, 4'd0, 2'b10, 1'b0, 2'b11, 2'b10, 4'd6},
        {OP_WR,   1'b1, 2'b10, 4'd0, 2'b10, 1'b0, 2'b11, 2'b10, 4'd5},  // R5
        {OP_IDLE, 1'b1, 2'b00, 4'd0, 2'b10, 1'b0, 2'b11, 2'b10, 4'd5},
        {OP_RTI,  1'b1, 2'b00, 4'd0, 2'b10, 1'b0, 2'b11, 2'b00, 4'd5},
        {OP_WR,   1'b0, 2'b11, 4'd0, 2'b10, 1'b1, 2'b11, 2'b00, 4'd11}, // R11
        {OP_WAIT, 1'b0, 2'b00, 4'd1, 2'b11, 1'b0, 2'b10, 2'b00, 4'd11},
        {OP_RTI,  1'b0, 2'b00, 4'd0, 2'b11, 1'b0, 2'b00, 2'b00, 4'd4},
        {OP_WR,   1'b0, 2'b00, 4'd0, 2'b11, 1'b0, 2'b00, 2'b00, 4'd11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_page = '0, bus_addr = '0;
    logic [1:0] bus_wdata = '0, bus_rdata;
    logic [1:0] idle_stb = '0, rti_stb = '0, handler_req, core_clk_en;
    logic       gen_run, mem_block;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    pwr_ctl #(.LOCK_CYCLES(LK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_page(bus_page), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .idle_stb(idle_stb), .rti_stb(rti_stb),
        .handler_req(handler_req), .core_clk_en(core_clk_en),
        .gen_run(gen_run), .mem_block(mem_block)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [7:0] pg, input logic [7:0] ad, input logic [1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_page = pg; bus_addr = ad; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_core(input int c, input logic [1:0] d);
        wr_raw(8'h00, 8'(8'h08 + 2 * c), d);
    endtask

    task automatic rd_raw(input logic [7:0] pg, input logic [7:0] ad, output logic [1:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_page = pg; bus_addr = ad;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic strobe(input bit is_rti, input int c);
        if (is_rti) rti_stb[c] = 1'b1; else idle_stb[c] = 1'b1;
        @(negedge clk);
        rti_stb = '0; idle_stb = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [1:0] s0, s1, rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_raw(8'h00, 8'h08, s0);
        rd_raw(8'h00, 8'h0A, s1);
        chk("R1 clk_en", core_clk_en, 2'b11);
        chk("R1 mem_block", mem_block, 0);
        chk("R1 gen_run", gen_run, 1);
        chk("R1 status0", s0, 2'b00);
        chk("R1 status1", s1, 2'b00);
        chk("R1 handler_req", handler_req, 2'b00);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            case (v[19:18])
                OP_WR:   wr_core(int'(v[17]), v[16:15]);
                OP_IDLE: strobe(1'b0, int'(v[17]));
                OP_RTI:  strobe(1'b1, int'(v[17]));
                default: repeat (int'(v[14:11])) @(negedge clk);
            endcase
            rd_raw(8'h00, 8'h08, s0);
            rd_raw(8'h00, 8'h0A, s1);
            chk($sformatf("R%0d vec%0d clk_en", v[3:0], i), core_clk_en, v[10:9]);
            chk($sformatf("R%0d vec%0d mem_block", v[3:0], i), mem_block, v[8]);
            chk($sformatf("R%0d vec%0d status0", v[3:0], i), s0, v[7:6]);
            chk($sformatf("R%0d vec%0d status1", v[3:0], i), s1, v[5:4]);
        end

        // R2 handler request is a single-cycle pulse
        wr_core(0, 2'b01);
        chk("R2 req high", handler_req, 2'b01);
        @(negedge clk);
        chk("R2 req low", handler_req, 2'b00);
        strobe(1'b0, 0);

        // R10 writes off the map change nothing, reads off the map return 0
        wr_raw(8'h00, 8'h0C, 2'b10);
        rd_raw(8'h00, 8'h08, s0);
        chk("R10 bad addr", s0, 2'b11);
        wr_raw(8'h01, 8'h08, 2'b10);
        rd_raw(8'h00, 8'h08, s0);
        chk("R10 bad page", s0, 2'b11);
        rd_raw(8'h00, 8'h0C, rv);
        chk("R10 unmapped read", rv, 2'b00);

        // R7 generator stops once both cores are stopped
        wr_core(1, 2'b01);
        strobe(1'b0, 1);
        @(negedge clk);
        chk("R7 gen_run off", gen_run, 0);

        // R8 generator restarts, then clock after lock
        wr_core(0, 2'b10);
        @(negedge clk);
        chk("R8 gen_run on", gen_run, 1);
        repeat (LK + 1) @(negedge clk);
        chk("R8 clk_en after lock", core_clk_en, 2'b01);

        // R6 re-entry raises a fresh handler request
        wr_core(0, 2'b01);
        strobe(1'b1, 0);
        chk("R6 reentry req", handler_req, 2'b01);

        finish_run();
    end

endmodule